// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets boot firmware fetch small configuration items by key over a simple register interface. The host writes a 16-bit key to choose an item. The read position then returns to the item's first byte. Each later read of the data register returns the next bytes of that item. The items sit in a synchronous byte ROM. The ROM is split into a generic table and an architecture-local table, and each item has its own length. Contents are produced at elaboration from a fixed formula, so every byte is known in advance.

The parameter `COMBINED` picks one of two address maps.

- **Combined map:** byte-wide, in the style of port I/O. The selector and the data register overlap.
- **Split map:** a separate control register and a wide data register. One read of the data register packs up to `DATA_BYTES` item bytes.

In both maps, the first byte read ends up in the most significant position of the returned value. Positions past the end of the item are filled with zeros. Reads are served one byte at a time, and the port reports completion with a one-cycle response pulse.

Top module: `cfgkey_port`

## Requirements
- R1: After reset the selection is key 0 (`cur_sel` = 0x0000) at read position 0. Generic item 0 is the 4-byte signature `SIGNATURE`, with bits 31:24 as its first byte.
- R2: A select takes the item index from key bits 13:0 and the table from key bit 15 (0 = generic, 1 = architecture-local). Key bit 14 is ignored. After a valid select, `cur_sel` holds the key exactly as written.
- R3: If key bits 13:0 are not below `NUM_ITEMS`, the selection becomes invalid. `cur_sel` then reads 0xFFFF and every data read returns zero until the next valid select.
- R4: Every select, valid or not, sets the read position back to byte 0. Selecting the same key again restarts that item.
- R5: A data read of N bytes (where `acc_size` = N) returns the next N item bytes in the low 8·N bits of `rsp_data`. The earliest byte is the most significant, and the bits above 8·N are zero. The read position advances by one for each item byte consumed.
- R6: Once the read position reaches the item's length, every further byte position reads 0x00 and the position stops advancing. An item of length zero always reads zero.
- R7: Writes to the data register are accepted but have no effect. The selection and the read position are unchanged.
- R8: In the split map (`COMBINED`=0), `acc_addr`=0 is the control register and `acc_addr`=1 is the data register. Only the following accesses are accepted:
  - 2-byte writes to control;
  - reads and writes of 1 to `DATA_BYTES` bytes to data.

  Any other access, including one with `acc_rd` and `acc_wr` both high, is rejected. A rejection produces a one-cycle `rsp_err` pulse and has no other effect.
- R9: In the combined map (`COMBINED`=1), a 2-byte write at `acc_addr`=0 selects. A 1-byte read at either address reads one data byte. 1-byte writes, and 2-byte writes at `acc_addr`=1, have no effect. Every other access is rejected as in R8.
- R10: Generic item 1 is a 4-byte little-endian version word. Bit 0 is always 1 and bit 1 equals `HAS_DMA`, so its first byte is 0x01 or 0x03 and the rest are zero.
- R11: An accepted N-byte read raises `busy` from the next cycle. `rsp_valid` pulses high for one cycle 2·N clock edges after the accepting edge, and `busy` is low again at that point. Accesses presented while `busy` is high are dropped with no effect and no `rsp_err`.
- R12: Every other item (table t, index k) has length (k + 3·t) mod (`ITEM_BYTES`+1). Its byte j is (128·t + 16·k + j + 1) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 1 | Register offset (0 or 1) |
| acc_rd | input | 1 | Read request, one cycle |
| acc_wr | input | 1 | Write request, one cycle |
| acc_size | input | clog2(DATA_BYTES)+1 | Access size in bytes |
| acc_wdata | input | 16 | Write data; the key on a select |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_err | output | 1 | Rejected-access pulse |
| rsp_data | output | 8·DATA_BYTES | Packed read data |
| busy | output | 1 | Read in progress; inputs dropped |
| cur_sel | output | 16 | Current selection key, 0xFFFF when invalid |

## Verification
The bench sweeps every key of both tables with every read width. Each sweep reads past the item's end, so packing order, zero fill and the stalled read position are all exposed. A design that packed bytes in ascending order, kept counting past the length, or failed to rewind on reselect would return shifted or nonzero bytes. Keys with bit 14 set, keys just above the item count, and the all-ones index are selected to catch a wrong mask or an off-by-one range check. Rejected sizes, data writes and a select issued mid-read are each followed by a read that must resume at the exact old position, so any side effect shows up as a wrong byte.

// File: rtl/cfgkey_pkg.sv
`timescale 1ns/1ps
package cfgkey_pkg;

  localparam logic [15:0] KEY_NONE = 16'hFFFF;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FETCH = 2'd1,
    RD_SHIFT = 2'd2
  } rd_state_e;

  // Length of item k in table t for a ROM with nb bytes per slot.
  function automatic int item_len(input int t, input int k, input int nb);
    if (t == 0 && k < 2) return 4;
    return (k + 3 * t) % (nb + 1);
  endfunction

  // Byte j of item k in table t.
  function automatic logic [7:0] item_byte(input int t, input int k, input int j,
                                           input logic [31:0] sig, input bit dma);
    if (t == 0 && k == 0) return (j < 4) ? sig[31 - 8 * j -: 8] : 8'h00;
    if (t == 0 && k == 1) return (j == 0) ? {6'd0, dma, 1'b1} : 8'h00;
    return 8'((128 * t + 16 * k + j + 1) % 256);
  endfunction

endpackage

// File: rtl/cfgkey_rom.sv
`timescale 1ns/1ps
module cfgkey_rom import cfgkey_pkg::*; #(
  parameter int          NUM_ITEMS  = 8,
  parameter int          ITEM_BYTES = 8,
  parameter logic [31:0] SIGNATURE  = 32'h4346474B,
  parameter bit          HAS_DMA    = 1'b0,
  parameter int          IW         = 3,
  parameter int          LW         = 4
) (
  input  logic          clk,
  input  logic          rd_tbl,
  input  logic [IW-1:0] rd_idx,
  input  logic [LW-1:0] rd_off,
  output logic [7:0]    rom_q,
  input  logic          q_tbl,
  input  logic [IW-1:0] q_idx,
  output logic [LW-1:0] q_len
);

  localparam int DEPTH = 2 * NUM_ITEMS * ITEM_BYTES;
  localparam int NENT  = 2 * NUM_ITEMS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LIW   = (NENT > 1) ? $clog2(NENT) : 1;

  logic [7:0]    mem  [DEPTH];
  logic [LW-1:0] lens [NENT];
  logic [AW-1:0] addr;
  logic [LIW-1:0] lidx;

  initial begin
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < NUM_ITEMS; k++) begin
        lens[LIW'(t * NUM_ITEMS + k)] = LW'(item_len(t, k, ITEM_BYTES));
        for (int j = 0; j < ITEM_BYTES; j++) begin
          mem[AW'((t * NUM_ITEMS + k) * ITEM_BYTES + j)] =
            item_byte(t, k, j, SIGNATURE, HAS_DMA);
        end
      end
    end
  end

  // Clamp the byte offset: a position at the item end is never consumed.
  always_comb begin
    int o;
    o = (int'(rd_off) >= ITEM_BYTES) ? ITEM_BYTES - 1 : int'(rd_off);
    addr = AW'((int'(rd_tbl) * NUM_ITEMS + int'(rd_idx)) * ITEM_BYTES + o);
  end

  always_ff @(posedge clk) begin
    rom_q <= mem[addr];
  end

  always_comb begin
    int qi;
    qi = (int'(q_idx) < NUM_ITEMS) ? int'(q_idx) : 0;
    lidx = LIW'(int'(q_tbl) * NUM_ITEMS + qi);
  end

  assign q_len = lens[lidx];

endmodule

// File: rtl/cfgkey_decode.sv
`timescale 1ns/1ps
module cfgkey_decode #(
  parameter bit COMBINED   = 1'b0,
  parameter int DATA_BYTES = 4,
  parameter int SZW        = 3
) (
  input  logic           busy,
  input  logic           acc_addr,
  input  logic           acc_rd,
  input  logic           acc_wr,
  input  logic [SZW-1:0] acc_size,
  input  logic [15:0]    acc_wdata,
  output logic           do_sel,
  output logic [15:0]    sel_val,
  output logic           do_read,
  output logic [SZW-1:0] rd_bytes,
  output logic           do_reject
);

  logic any_acc, rd_only, wr_only;
  logic sel_ok, rd_ok, wnop_ok;

  assign any_acc = (acc_rd | acc_wr) & ~busy;
  assign rd_only = acc_rd & ~acc_wr;
  assign wr_only = acc_wr & ~acc_rd;

  generate
    if (COMBINED) begin : g_comb
      always_comb begin
        sel_ok  = wr_only && (int'(acc_size) == 2) && !acc_addr;
        rd_ok   = rd_only && (int'(acc_size) == 1);
        wnop_ok = wr_only && ((int'(acc_size) == 1) ||
                              ((int'(acc_size) == 2) && acc_addr));
      end
    end else begin : g_split
      logic in_rng;
      always_comb begin
        in_rng  = (int'(acc_size) >= 1) && (int'(acc_size) <= DATA_BYTES);
        sel_ok  = wr_only && !acc_addr && (int'(acc_size) == 2);
        rd_ok   = rd_only && acc_addr && in_rng;
        wnop_ok = wr_only && acc_addr && in_rng;
      end
    end
  endgenerate

  assign do_sel    = any_acc & sel_ok;
  assign do_read   = any_acc & rd_ok;
  assign do_reject = any_acc & ~(sel_ok | rd_ok | wnop_ok);
  assign sel_val   = acc_wdata;
  assign rd_bytes  = acc_size;

endmodule

// File: rtl/cfgkey_select.sv
`timescale 1ns/1ps
module cfgkey_select import cfgkey_pkg::*; #(
  parameter int NUM_ITEMS  = 8,
  parameter int ITEM_BYTES = 8,
  parameter int IW         = 3,
  parameter int LW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_sel,
  input  logic [15:0]   sel_val,
  output logic          q_tbl,
  output logic [IW-1:0] q_idx,
  input  logic [LW-1:0] q_len,
  output logic [15:0]   cur_sel,
  output logic          cur_tbl,
  output logic [IW-1:0] cur_idx,
  output logic [LW-1:0] cur_len
);

  logic hit;

  // Index is the low 14 key bits; bit 15 picks the table.
  assign hit   = ({2'b00, sel_val[13:0]} < 16'(NUM_ITEMS));
  assign q_tbl = sel_val[15];
  assign q_idx = sel_val[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sel <= 16'h0000;
      cur_tbl <= 1'b0;
      cur_idx <= '0;
      cur_len <= LW'(item_len(0, 0, ITEM_BYTES));
    end else if (do_sel) begin
      if (hit) begin
        cur_sel <= sel_val;
        cur_tbl <= sel_val[15];
        cur_idx <= sel_val[IW-1:0];
        cur_len <= q_len;
      end else begin
        cur_sel <= KEY_NONE;
        cur_tbl <= 1'b0;
        cur_idx <= '0;
        cur_len <= '0;
      end
    end
  end

endmodule

// File: rtl/cfgkey_reader.sv
`timescale 1ns/1ps
module cfgkey_reader import cfgkey_pkg::*; #(
  parameter int DATA_BYTES = 4,
  parameter int SZW        = 3,
  parameter int LW         = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    do_read,
  input  logic [SZW-1:0]          rd_bytes,
  input  logic                    sel_pulse,
  input  logic [LW-1:0]           sel_len,
  input  logic [7:0]              rom_q,
  output logic [LW-1:0]           rd_off,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [8*DATA_BYTES-1:0] rsp_data
);

  localparam int DW = 8 * DATA_BYTES;

  rd_state_e      state;
  logic [SZW-1:0] cnt;
  logic [DW-1:0]  acc;
  logic [DW-1:0]  shifted;
  logic           avail_q;

  // Earliest byte ends up most significant; past the end shift in zero.
  assign shifted = (acc << 8) | DW'(avail_q ? rom_q : 8'h00);
  assign busy    = (state != RD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_IDLE;
      cnt       <= '0;
      acc       <= '0;
      avail_q   <= 1'b0;
      rd_off    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (sel_pulse) rd_off <= '0;
      case (state)
        RD_IDLE: begin
          if (do_read) begin
            state <= RD_FETCH;
            cnt   <= rd_bytes;
            acc   <= '0;
          end
        end
        RD_FETCH: begin
          avail_q <= (rd_off < sel_len);
          state   <= RD_SHIFT;
        end
        RD_SHIFT: begin
          acc <= shifted;
          if (avail_q) rd_off <= rd_off + LW'(1);
          cnt <= cnt - SZW'(1);
          if (cnt == SZW'(1)) begin
            rsp_valid <= 1'b1;
            rsp_data  <= shifted;
            state     <= RD_IDLE;
          end else begin
            state <= RD_FETCH;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgkey_port.sv
`timescale 1ns/1ps
module cfgkey_port import cfgkey_pkg::*; #(
  parameter int          NUM_ITEMS  = 8,
  parameter int          ITEM_BYTES = 8,
  parameter int          DATA_BYTES = 4,
  parameter bit          COMBINED   = 1'b0,
  parameter bit          HAS_DMA    = 1'b0,
  parameter logic [31:0] SIGNATURE  = 32'h4346474B
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc_addr,
  input  logic                          acc_rd,
  input  logic                          acc_wr,
  input  logic [$clog2(DATA_BYTES):0]   acc_size,
  input  logic [15:0]                   acc_wdata,
  output logic                          rsp_valid,
  output logic                          rsp_err,
  output logic [8*DATA_BYTES-1:0]       rsp_data,
  output logic                          busy,
  output logic [15:0]                   cur_sel
);

  localparam int SZW = $clog2(DATA_BYTES) + 1;
  localparam int DW  = 8 * DATA_BYTES;
  localparam int IW  = (NUM_ITEMS > 1) ? $clog2(NUM_ITEMS) : 1;
  localparam int LW  = $clog2(ITEM_BYTES + 1);

  logic           do_sel, do_read, do_reject;
  logic [15:0]    sel_val;
  logic [SZW-1:0] rd_bytes;
  logic           q_tbl;
  logic [IW-1:0]  q_idx;
  logic [LW-1:0]  q_len;
  logic           cur_tbl;
  logic [IW-1:0]  cur_idx;
  logic [LW-1:0]  sel_len;
  logic [LW-1:0]  rd_offset;
  logic [7:0]     rom_q;

  cfgkey_decode #(.COMBINED(COMBINED), .DATA_BYTES(DATA_BYTES), .SZW(SZW)) u_dec (
    .busy(busy), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .do_sel(do_sel),
    .sel_val(sel_val), .do_read(do_read), .rd_bytes(rd_bytes),
    .do_reject(do_reject)
  );

  cfgkey_select #(.NUM_ITEMS(NUM_ITEMS), .ITEM_BYTES(ITEM_BYTES), .IW(IW), .LW(LW)) u_sel (
    .clk(clk), .rst(rst), .do_sel(do_sel), .sel_val(sel_val),
    .q_tbl(q_tbl), .q_idx(q_idx), .q_len(q_len), .cur_sel(cur_sel),
    .cur_tbl(cur_tbl), .cur_idx(cur_idx), .cur_len(sel_len)
  );

  cfgkey_rom #(.NUM_ITEMS(NUM_ITEMS), .ITEM_BYTES(ITEM_BYTES), .SIGNATURE(SIGNATURE),
               .HAS_DMA(HAS_DMA), .IW(IW), .LW(LW)) u_rom (
    .clk(clk), .rd_tbl(cur_tbl), .rd_idx(cur_idx), .rd_off(rd_offset),
    .rom_q(rom_q), .q_tbl(q_tbl), .q_idx(q_idx), .q_len(q_len)
  );

  cfgkey_reader #(.DATA_BYTES(DATA_BYTES), .SZW(SZW), .LW(LW)) u_rd (
    .clk(clk), .rst(rst), .do_read(do_read), .rd_bytes(rd_bytes),
    .sel_pulse(do_sel), .sel_len(sel_len), .rom_q(rom_q), .rd_off(rd_offset),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_err <= 1'b0;
    else     rsp_err <= do_reject;
  end

endmodule

// File: rtl/cfgkey_port_chk.sv
`timescale 1ns/1ps
module cfgkey_port_chk #(
  parameter int LW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          busy,
  input logic          do_sel,
  input logic [15:0]   cur_sel,
  input logic [LW-1:0] rd_offset,
  input logic [LW-1:0] sel_len,
  input logic [DW-1:0] rsp_data
);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_idle_at_resp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  a_r8_err_not_data: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !rsp_valid);

  a_r4_select_rewinds: assert property (@(posedge clk) disable iff (rst)
    do_sel |=> (rd_offset == '0));

  a_r6_offset_in_item: assert property (@(posedge clk) disable iff (rst)
    rd_offset <= sel_len);

  a_r3_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cur_sel == 16'hFFFF) |-> (rsp_data == '0));

endmodule

bind cfgkey_port cfgkey_port_chk #(.LW(LW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .busy(busy), .do_sel(do_sel), .cur_sel(cur_sel), .rd_offset(rd_offset),
  .sel_len(sel_len), .rsp_data(rsp_data)
);

// File: tb/sim_cfgkey_port.sv
`timescale 1ns/1ps
module sim_cfgkey_port;

  localparam logic [31:0] SIG = 32'h4346474B;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst;

  logic        a_addr, a_rd, a_wr, a_v, a_e, a_busy;
  logic [2:0]  a_size;
  logic [15:0] a_wd, a_sel;
  logic [31:0] a_d;
  logic        b_addr, b_rd, b_wr, b_v, b_e, b_busy;
  logic [1:0]  b_size;
  logic [15:0] b_wd, b_sel, b_d;

  cfgkey_port #(.NUM_ITEMS(8), .ITEM_BYTES(8), .DATA_BYTES(4), .COMBINED(1'b0),
                .HAS_DMA(1'b1), .SIGNATURE(SIG)) u0 (
    .clk(clk), .rst(rst), .acc_addr(a_addr), .acc_rd(a_rd), .acc_wr(a_wr),
    .acc_size(a_size), .acc_wdata(a_wd), .rsp_valid(a_v), .rsp_err(a_e),
    .rsp_data(a_d), .busy(a_busy), .cur_sel(a_sel));

  cfgkey_port #(.NUM_ITEMS(4), .ITEM_BYTES(4), .DATA_BYTES(2), .COMBINED(1'b1),
                .HAS_DMA(1'b0), .SIGNATURE(SIG)) u1 (
    .clk(clk), .rst(rst), .acc_addr(b_addr), .acc_rd(b_rd), .acc_wr(b_wr),
    .acc_size(b_size), .acc_wdata(b_wd), .rsp_valid(b_v), .rsp_err(b_e),
    .rsp_data(b_d), .busy(b_busy), .cur_sel(b_sel));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int moff;

  function automatic int m_len(bit inst, int t, int k);
    int nb = inst ? 4 : 8;
    if (t == 0 && k < 2) return 4;
    return (k + 3 * t) % (nb + 1);
  endfunction

  function automatic logic [7:0] m_byte(bit inst, int t, int k, int j);
    if (t == 0 && k == 0) return SIG[31 - 8 * j -: 8];
    if (t == 0 && k == 1) return (j == 0) ? (inst ? 8'h01 : 8'h03) : 8'h00;
    return 8'((t * 128 + k * 16 + j + 1) % 256);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(bit inst, bit addr, bit rd, bit wr, int size, logic [15:0] wd);
    @(negedge clk);
    if (!inst) begin
      a_addr = addr; a_rd = rd; a_wr = wr; a_size = 3'(size); a_wd = wd;
    end else begin
      b_addr = addr; b_rd = rd; b_wr = wr; b_size = 2'(size); b_wd = wd;
    end
    @(negedge clk);
    a_rd = 1'b0; a_wr = 1'b0; b_rd = 1'b0; b_wr = 1'b0;
  endtask

  task automatic do_rd(bit inst, bit addr, int n, output logic [31:0] d,
                       output bit e, output int cyc);
    drive(inst, addr, 1'b1, 1'b0, n, 16'h0);
    cyc = 1;
    while (!(inst ? (b_v | b_e) : (a_v | a_e)) && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    d = inst ? 32'(b_d) : a_d;
    e = inst ? b_e : a_e;
  endtask

  task automatic rd_chk(bit inst, bit addr, int n, int t, int k, bit inval, string req);
    logic [31:0] exp = 32'h0;
    logic [31:0] d;
    bit e;
    int cyc;
    int len = inval ? 0 : m_len(inst, t, k);
    for (int i = 0; i < n; i++) begin
      if (moff < len) begin
        exp = (exp << 8) | 32'(m_byte(inst, t, k, moff));
        moff++;
      end else begin
        exp = exp << 8;
      end
    end
    do_rd(inst, addr, n, d, e, cyc);
    check(req, d, exp);
    check("R11 latency", 32'(cyc), 32'(2 * n + 1));
  endtask

  task automatic sel(bit inst, logic [15:0] key);
    drive(inst, 1'b0, 1'b0, 1'b1, 2, key);
    moff = 0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual hung expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    bit e;
    int cyc;
    a_addr = 0; a_rd = 0; a_wr = 0; a_size = 0; a_wd = 0;
    b_addr = 0; b_rd = 0; b_wr = 0; b_size = 0; b_wd = 0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and signature
    check("R1 sel u0", 32'(a_sel), 32'h0);
    check("R1 sel u1", 32'(b_sel), 32'h0);
    check("R1 busy", 32'(a_busy), 32'h0);
    moff = 0;
    rd_chk(1'b0, 1'b1, 4, 0, 0, 1'b0, "R1 signature");
    moff = 0;
    for (int j = 0; j < 4; j++) rd_chk(1'b1, j[0], 1, 0, 0, 1'b0, "R1 R9 signature byte");

    // R2 R4 R5 R6 R12: full sweep of split instance
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 8; k++) begin
        for (int n = 1; n <= 4; n++) begin
          sel(1'b0, 16'((t << 15) | k));
          check("R2 R4 cur_sel", 32'(a_sel), 32'((t << 15) | k));
          for (int r = 0; r < 8 / n + 2; r++)
            rd_chk(1'b0, 1'b1, n, t, k, 1'b0, "R5 R6 R12 packed data");
        end
      end
    end

    // R2: bit 14 ignored, bit 15 table
    sel(1'b0, 16'h4002);
    check("R2 alias sel", 32'(a_sel), 32'h4002);
    rd_chk(1'b0, 1'b1, 4, 0, 2, 1'b0, "R2 alias data");
    sel(1'b0, 16'hC003);
    rd_chk(1'b0, 1'b1, 4, 1, 3, 1'b0, "R2 arch data");

    // R3: out-of-range keys
    foreach (d[i]) begin end
    for (int i = 0; i < 6; i++) begin
      logic [15:0] bad;
      case (i)
        0: bad = 16'h0008;
        1: bad = 16'h0009;
        2: bad = 16'h3FFF;
        3: bad = 16'h8008;
        4: bad = 16'hBFFF;
        default: bad = 16'h7FFF;
      endcase
      sel(1'b0, bad);
      check("R3 invalid sel", 32'(a_sel), 32'hFFFF);
      rd_chk(1'b0, 1'b1, 4, 0, 0, 1'b1, "R3 invalid data");
    end
    sel(1'b0, 16'h0002);
    rd_chk(1'b0, 1'b1, 2, 0, 2, 1'b0, "R3 recovery");

    // R10: identification word
    sel(1'b0, 16'h0001);
    do_rd(1'b0, 1'b1, 4, d, e, cyc);
    check("R10 version u0", d, 32'h03000000);

    // R7: data writes have no effect
    sel(1'b0, 16'h0007);
    rd_chk(1'b0, 1'b1, 2, 0, 7, 1'b0, "R7 pre");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 4, 16'h1234);
    check("R7 no err", 32'(a_e), 32'h0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1, 16'h0055);
    check("R7 sel kept", 32'(a_sel), 32'h7);
    rd_chk(1'b0, 1'b1, 2, 0, 7, 1'b0, "R7 continues");

    // R8: rejected accesses
    sel(1'b0, 16'h0005);
    rd_chk(1'b0, 1'b1, 1, 0, 5, 1'b0, "R8 pre");
    for (int i = 0; i < 7; i++) begin
      case (i)
        0: drive(1'b0, 1'b0, 1'b1, 1'b0, 1, 16'h0003);
        1: drive(1'b0, 1'b0, 1'b0, 1'b1, 1, 16'h0003);
        2: drive(1'b0, 1'b0, 1'b0, 1'b1, 4, 16'h0003);
        3: drive(1'b0, 1'b1, 1'b1, 1'b0, 0, 16'h0003);
        4: drive(1'b0, 1'b1, 1'b1, 1'b0, 5, 16'h0003);
        5: drive(1'b0, 1'b1, 1'b1, 1'b1, 1, 16'h0003);
        default: drive(1'b0, 1'b1, 1'b0, 1'b1, 0, 16'h0003);
      endcase
      check("R8 err pulse", 32'(a_e), 32'h1);
      check("R8 sel kept", 32'(a_sel), 32'h5);
    end
    rd_chk(1'b0, 1'b1, 1, 0, 5, 1'b0, "R8 continues");

    // R11: busy, dropped access, single pulse
    sel(1'b0, 16'h0006);
    @(negedge clk);
    a_addr = 1'b1; a_rd = 1'b1; a_size = 3'd4;
    @(negedge clk);
    a_rd = 1'b0;
    check("R11 busy", 32'(a_busy), 32'h1);
    a_addr = 1'b0; a_wr = 1'b1; a_size = 3'd2; a_wd = 16'h0002;
    @(negedge clk);
    a_wr = 1'b0;
    cyc = 2;
    while (!a_v && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    check("R11 drop latency", 32'(cyc), 32'd9);
    check("R11 data", a_d, 32'h61626364);
    check("R11 sel kept", 32'(a_sel), 32'h6);
    @(negedge clk);
    check("R11 pulse", 32'(a_v), 32'h0);
    moff = 4;
    rd_chk(1'b0, 1'b1, 4, 0, 6, 1'b0, "R6 R11 tail");

    // R9: combined map
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2, 16'h8001);
    moff = 0;
    check("R9 sel", 32'(b_sel), 32'h8001);
    for (int j = 0; j < 4; j++) rd_chk(1'b1, j[0], 1, 1, 1, 1'b0, "R9 byte");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2, 16'h0);
    check("R9 wide read rejected", 32'(b_e), 32'h1);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2, 16'h0);
    check("R9 wide read rejected addr0", 32'(b_e), 32'h1);
    sel(1'b1, 16'h0003);
    rd_chk(1'b1, 1'b1, 1, 0, 3, 1'b0, "R9 pre");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1, 16'h00AA);
    check("R7 R9 byte write", 32'(b_e), 32'h0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1, 16'h0002);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2, 16'h0002);
    check("R9 no select at 1", 32'(b_sel), 32'h3);
    for (int j = 0; j < 3; j++) rd_chk(1'b1, 1'b0, 1, 0, 3, 1'b0, "R7 R9 continues");
    sel(1'b1, 16'h0004);
    check("R3 u1 invalid", 32'(b_sel), 32'hFFFF);
    sel(1'b1, 16'h0001);
    for (int j = 0; j < 4; j++) rd_chk(1'b1, 1'b1, 1, 0, 1, 1'b0, "R10 version u1");

    summary();
  end

endmodule